// File: doc/BRIEF.md
# Page Walker Start Arbiter

This block sits in front of a hardware page-table walker and decides, each cycle, whether the walker may begin a new translation and for which side. It may start one for an instruction-TLB miss (including an access/dirty update request from the fetch side) or for a data-TLB miss. It also decides when a walk-related flush goes to the load/store unit.

Instruction-side walks are deferred in two cases. The first is while the data cache or bus reports a stall. The second is while the memory stage still holds a committed data operation: a load, store, atomic or cache-management op. This keeps the walk from moving the data-cache array index away from an access that has not yet retired. Data-side walks are never deferred by the memory-stage hold-off and win when both sides are eligible in the same cycle.

Once granted, the side is held as the active walk until the walker reports fault or done. The load/store flush is raised only while a data-side walk is active. Grants are combinational, so a deferred instruction walk starts in the very cycle its hold-off clears.

Top module: `ptw_start_arb`

## Requirements
- R1: After reset, `walk_side` is 2'b00 (none), and `grant_instr`, `grant_data` and `lsu_flush` are low while no request is present.
- R2: `grant_instr` is high in a cycle only if `imiss_req` is high, `cache_busy` is low and no memory-stage access is pending. The same cycle must also be a start cycle (R6) with `dmiss_req` low. When all of these hold, it is high.
- R3: A memory-stage access counts as pending when any bit of `mem_rw` or any bit of `mem_cmo` is set. Each bit alone blocks an instruction grant.
- R4: `grant_data` is high in every start cycle (R6) in which `dmiss_req` is high, regardless of `cache_busy`, `mem_rw` and `mem_cmo`.
- R5: When both requests are eligible in the same start cycle, only `grant_data` is raised.
- R6: A start cycle is one where `walker_state` is 2'b00 (idle) and `walk_side` is 2'b00. No grant is raised in any other cycle, and at most one grant is high at a time.
- R7: From the clock edge after a grant, `walk_side` holds 2'b01 for instruction or 2'b10 for data. It keeps that value until the edge after a cycle with `walker_state` 2'b10 (fault) or 2'b11 (done), after which it returns to 2'b00. Encoding of `walker_state`: 2'b01 is walking.
- R8: `lsu_flush` is high exactly when `walk_side` is 2'b10 and either `walker_state` is 2'b10 (fault) or `trap` is high. It is never raised while an instruction walk is active.
- R9: A deferred instruction request is granted in the first cycle in which its hold-off has cleared, so a data operation leaving the memory stage cannot leave the instruction walk waiting forever.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imiss_req | input | 1 | Instruction-side miss or update request pending |
| dmiss_req | input | 1 | Data-side miss request pending |
| cache_busy | input | 1 | Data cache or bus stall |
| mem_rw | input | RW_W | Memory-stage read/write request bits |
| mem_cmo | input | CMO_W | Memory-stage cache-management op bits |
| walker_state | input | 2 | Walker status: 00 idle, 01 walking, 10 fault, 11 done |
| trap | input | 1 | Trap indication |
| grant_instr | output | 1 | Start an instruction-side walk this cycle |
| grant_data | output | 1 | Start a data-side walk this cycle |
| walk_side | output | 2 | Active walk: 00 none, 01 instruction, 10 data |
| lsu_flush | output | 1 | Flush request to the load/store unit |

## Verification
A wrong pending decode or a missing busy gate shows as `grant_instr` rising in the same cycle that a memory-stage bit or the stall is high. A lost or stale active-side register shows one edge later as the wrong `walk_side` code. It can also show as a second grant while a walk is in progress, or as `lsu_flush` rising during an instruction walk. Every such fault is visible at the ports within one cycle of the stimulus that provokes it, so each scenario samples grants combinationally and `walk_side` after the following edge.

// File: rtl/ptw_arb_pkg.sv
package ptw_arb_pkg;

  typedef enum logic [1:0] {
    SIDE_NONE  = 2'b00,
    SIDE_INSTR = 2'b01,
    SIDE_DATA  = 2'b10
  } walk_side_e;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'b00,
    WS_BUSY  = 2'b01,
    WS_FAULT = 2'b10,
    WS_DONE  = 2'b11
  } walker_st_e;

  // A walk ends on the cycle the walker reports fault or done.
  function automatic logic f_walk_ends(input walker_st_e st);
    return (st == WS_FAULT) || (st == WS_DONE);
  endfunction

endpackage

// File: rtl/ptw_arb_elig.sv
module ptw_arb_elig
  import ptw_arb_pkg::*;
#(
  parameter int RW_W  = 2,
  parameter int CMO_W = 4
) (
  input  logic             imiss_req,
  input  logic             dmiss_req,
  input  logic             cache_busy,
  input  logic [RW_W-1:0]  mem_rw,
  input  logic [CMO_W-1:0] mem_cmo,
  input  logic             can_start,
  output logic             mem_pending,
  output logic             grant_instr,
  output logic             grant_data
);

  function automatic logic f_pending(input logic [RW_W-1:0] rw,
                                     input logic [CMO_W-1:0] cmo);
    return (|rw) | (|cmo);
  endfunction

  logic instr_ok;
  logic data_ok;

  always_comb begin
    mem_pending = f_pending(mem_rw, mem_cmo);
    instr_ok    = imiss_req & ~cache_busy & ~mem_pending;
    data_ok     = dmiss_req;
    grant_data  = can_start & data_ok;
    grant_instr = can_start & instr_ok & ~data_ok;
  end

endmodule

// File: rtl/ptw_arb_track.sv
module ptw_arb_track
  import ptw_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grant_instr,
  input  logic       grant_data,
  input  walker_st_e wstate,
  output walk_side_e side
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      side <= SIDE_NONE;
    end else if (side != SIDE_NONE && f_walk_ends(wstate)) begin
      side <= SIDE_NONE;
    end else if (grant_data) begin
      side <= SIDE_DATA;
    end else if (grant_instr) begin
      side <= SIDE_INSTR;
    end
  end

endmodule

// File: rtl/ptw_arb_flush.sv
module ptw_arb_flush
  import ptw_arb_pkg::*;
(
  input  walk_side_e side,
  input  walker_st_e wstate,
  input  logic       trap,
  output logic       lsu_flush
);

  logic data_active;

  always_comb begin
    data_active = (side == SIDE_DATA);
    lsu_flush   = data_active & ((wstate == WS_FAULT) | trap);
  end

endmodule

// File: rtl/ptw_start_arb.sv
module ptw_start_arb
  import ptw_arb_pkg::*;
#(
  parameter int RW_W  = 2,
  parameter int CMO_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             imiss_req,
  input  logic             dmiss_req,
  input  logic             cache_busy,
  input  logic [RW_W-1:0]  mem_rw,
  input  logic [CMO_W-1:0] mem_cmo,
  input  logic [1:0]       walker_state,
  input  logic             trap,
  output logic             grant_instr,
  output logic             grant_data,
  output logic [1:0]       walk_side,
  output logic             lsu_flush
);

  walker_st_e wstate;
  walk_side_e side;
  logic       can_start;
  logic       mem_pending;

  assign wstate    = walker_st_e'(walker_state);
  assign can_start = (wstate == WS_IDLE) && (side == SIDE_NONE);

  ptw_arb_elig #(.RW_W(RW_W), .CMO_W(CMO_W)) elig_i (
    .imiss_req   (imiss_req),
    .dmiss_req   (dmiss_req),
    .cache_busy  (cache_busy),
    .mem_rw      (mem_rw),
    .mem_cmo     (mem_cmo),
    .can_start   (can_start),
    .mem_pending (mem_pending),
    .grant_instr (grant_instr),
    .grant_data  (grant_data)
  );

  ptw_arb_track track_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_instr (grant_instr),
    .grant_data  (grant_data),
    .wstate      (wstate),
    .side        (side)
  );

  ptw_arb_flush flush_i (
    .side      (side),
    .wstate    (wstate),
    .trap      (trap),
    .lsu_flush (lsu_flush)
  );

  assign walk_side = side;

endmodule

// File: rtl/ptw_start_arb_chk.sv
module ptw_start_arb_chk #(
  parameter int RW_W  = 2,
  parameter int CMO_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             imiss_req,
  input logic             dmiss_req,
  input logic             cache_busy,
  input logic [RW_W-1:0]  mem_rw,
  input logic [CMO_W-1:0] mem_cmo,
  input logic [1:0]       walker_state,
  input logic             trap,
  input logic             grant_instr,
  input logic             grant_data,
  input logic [1:0]       walk_side,
  input logic             lsu_flush
);

  assert_no_igrant_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_instr |-> (mem_rw == '0) && (mem_cmo == '0));

  assert_no_igrant_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_instr |-> !cache_busy && imiss_req);

  assert_data_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_instr |-> !dmiss_req);

  assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_instr, grant_data}));

  assert_grant_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_instr || grant_data) |-> (walker_state == 2'b00) && (walk_side == 2'b00));

  assert_data_unblocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dmiss_req && walker_state == 2'b00 && walk_side == 2'b00) |-> grant_data);

  assert_data_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_data |=> (walk_side == 2'b10));

  assert_instr_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_instr |=> (walk_side == 2'b01));

  assert_flush_data_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lsu_flush |-> (walk_side == 2'b10));

endmodule

bind ptw_start_arb ptw_start_arb_chk #(.RW_W(RW_W), .CMO_W(CMO_W)) chk_i (.*);

// File: tb/ptw_start_arb_tb.sv
module ptw_start_arb_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RW_W  = 2;
  localparam int CMO_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             imiss_req = 1'b0;
  logic             dmiss_req = 1'b0;
  logic             cache_busy = 1'b0;
  logic [RW_W-1:0]  mem_rw = '0;
  logic [CMO_W-1:0] mem_cmo = '0;
  logic [1:0]       walker_state = 2'b00;
  logic             trap = 1'b0;
  logic             grant_instr;
  logic             grant_data;
  logic [1:0]       walk_side;
  logic             lsu_flush;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_start_arb #(.RW_W(RW_W), .CMO_W(CMO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .imiss_req(imiss_req), .dmiss_req(dmiss_req),
    .cache_busy(cache_busy), .mem_rw(mem_rw), .mem_cmo(mem_cmo),
    .walker_state(walker_state), .trap(trap), .grant_instr(grant_instr),
    .grant_data(grant_data), .walk_side(walk_side), .lsu_flush(lsu_flush)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Advance to the next falling edge, then let combinational logic settle.
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic quiet();
    imiss_req = 0; dmiss_req = 0; cache_busy = 0;
    mem_rw = '0; mem_cmo = '0; walker_state = 2'b00; trap = 0;
  endtask

  // Walker goes busy, then done, then idle; side clears after done.
  task automatic close_walk(input int side_exp, input string req);
    walker_state = 2'b01; imiss_req = 0; dmiss_req = 0; #1;
    check({req, " side while walking"}, walk_side, side_exp);
    check({req, " no grant while walking"}, grant_instr + grant_data, 0);
    step();
    walker_state = 2'b11; #1;
    check({req, " side on done"}, walk_side, side_exp);
    step();
    walker_state = 2'b00; #1;
    check({req, " side cleared"}, walk_side, 0);
  endtask

  task automatic t_reset();
    quiet();
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
    check("R1 walk_side", walk_side, 0);
    check("R1 grants", grant_instr + grant_data, 0);
    check("R1 flush", lsu_flush, 0);
  endtask

  task automatic t_instr_plain();
    quiet(); imiss_req = 1; #1;
    check("R2 instr grant", grant_instr, 1);
    check("R2 no data grant", grant_data, 0);
    step();
    check("R7 instr latched", walk_side, 1);
    check("R6 no grant with active side", grant_instr, 0);
    close_walk(1, "R7");
  endtask

  task automatic t_busy();
    quiet(); imiss_req = 1; cache_busy = 1; #1;
    check("R2 busy blocks", grant_instr, 0);
    step();
    check("R2 busy no latch", walk_side, 0);
    cache_busy = 0; #1;
    check("R2 grant after busy", grant_instr, 1);
    step();
    close_walk(1, "R2");
  endtask

  task automatic t_pending_bits();
    for (int b = 0; b < RW_W; b++) begin
      quiet(); imiss_req = 1; mem_rw = RW_W'(1) << b; #1;
      check($sformatf("R3 rw bit %0d blocks", b), grant_instr, 0);
    end
    for (int b = 0; b < CMO_W; b++) begin
      quiet(); imiss_req = 1; mem_cmo = CMO_W'(1) << b; #1;
      check($sformatf("R3 cmo bit %0d blocks", b), grant_instr, 0);
    end
    quiet(); step();
    check("R3 nothing latched", walk_side, 0);
  endtask

  task automatic t_data_unblocked();
    quiet(); dmiss_req = 1; cache_busy = 1; mem_rw = '1; mem_cmo = '1; #1;
    check("R4 data grant despite hold-off", grant_data, 1);
    step();
    check("R4 data latched", walk_side, 2);
    mem_rw = '0; mem_cmo = '0; cache_busy = 0;
    close_walk(2, "R4");
  endtask

  task automatic t_priority();
    quiet(); imiss_req = 1; dmiss_req = 1; #1;
    check("R5 data wins", grant_data, 1);
    check("R5 instr held", grant_instr, 0);
    step();
    check("R5 data side", walk_side, 2);
    close_walk(2, "R5");
    imiss_req = 1; #1;
    check("R5 instr after data walk", grant_instr, 1);
    step();
    close_walk(1, "R5");
  endtask

  task automatic t_not_idle();
    quiet(); dmiss_req = 1; walker_state = 2'b01; #1;
    check("R6 no grant walker busy", grant_data, 0);
    walker_state = 2'b10; #1;
    check("R6 no grant walker fault", grant_data, 0);
    step();
    check("R6 no latch", walk_side, 0);
    quiet();
  endtask

  task automatic t_flush();
    quiet(); dmiss_req = 1; #1;
    check("R8 no flush before walk", lsu_flush, 0);
    step();
    dmiss_req = 0; walker_state = 2'b01; #1;
    check("R8 no flush while data walking", lsu_flush, 0);
    trap = 1; #1;
    check("R8 flush on trap in data walk", lsu_flush, 1);
    trap = 0; walker_state = 2'b10; #1;
    check("R8 flush on data fault", lsu_flush, 1);
    step();
    walker_state = 2'b00; #1;
    check("R7 side cleared after fault", walk_side, 0);
    check("R8 flush drops", lsu_flush, 0);
    imiss_req = 1; #1;
    step();
    imiss_req = 0; walker_state = 2'b10; trap = 1; #1;
    check("R8 instr side", walk_side, 1);
    check("R8 no flush on instr fault", lsu_flush, 0);
    step();
    quiet(); #1;
    check("R8 instr side cleared", walk_side, 0);
  endtask

  task automatic t_deferred();
    quiet(); imiss_req = 1; mem_rw = 2'b01; #1;
    for (int c = 0; c < 3; c++) begin
      check("R9 held while load pending", grant_instr, 0);
      step();
    end
    mem_rw = '0; mem_cmo = 4'b0100; #1;
    check("R9 held while cmo pending", grant_instr, 0);
    step();
    mem_cmo = '0; #1;
    check("R9 granted when op leaves", grant_instr, 1);
    step();
    check("R9 instr latched", walk_side, 1);
    close_walk(1, "R9");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_instr_plain();
    t_busy();
    t_pending_bits();
    t_data_unblocked();
    t_priority();
    t_not_idle();
    t_flush();
    t_deferred();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule